// File: doc/BRIEF.md
# Binary-Field Fermat Inverter

This block computes the multiplicative inverse of an element of GF(2^M) in polynomial basis. It raises the operand to the power 2^M − 2, which by Fermat's little theorem equals a^(-1). It does this with an Itoh-Tsujii addition chain, so almost all of the work is done by a one-cycle squarer and only a few field multiplications are needed. It is meant to run once at the end of a projective-coordinate scalar multiplication, when the result is turned back into affine form.

The controller reads the bits of M−1 from the most significant bit to the least. It holds β_k = a^(2^k − 1) and starts with k = 1. For each later bit it doubles k: it squares β_k k times and then multiplies by the saved β_k. When the bit is 1 it also adds one step: one squaring, then a multiplication by a. When the bits are used up, one last squaring gives a^(2^M − 2). A zero operand has no inverse. It gives result 0 with the error flag set and starts no multiplication.

The states are IDLE (wait for start and latch the operand), DBL_SQR (squaring run that doubles k), DBL_MUL (multiply by the saved β), INC_SQR (single squaring), INC_MUL (multiply by the operand) and FINAL (last squaring and publish). The transitions are:
- IDLE→DBL_SQR on a nonzero start when chain bits remain.
- IDLE→FINAL on a nonzero start when no bits remain.
- DBL_SQR→DBL_MUL when the squaring count reaches its last square.
- DBL_MUL→INC_SQR when the current bit is 1. When it is 0, DBL_MUL goes to DBL_SQR or FINAL, depending on whether bits remain.
- INC_SQR→INC_MUL always.
- INC_MUL→DBL_SQR or FINAL, depending on whether bits remain.
- FINAL→IDLE always.

Top module: `gf_fermat_inv`

## Requirements
- R1: For every nonzero a, the product a·inv_out reduced by x^M + POLY equals 1. POLY bit i is the coefficient of x^i and bit i of a field element is its x^i coefficient.
- R2: A start with a_in equal to zero gives done with zero_err = 1 and inv_out = 0, and mul_issue never goes high for that operation.
- R3: A nonzero operation raises mul_issue for exactly floor(log2(M−1)) + HW(M−1) − 1 cycles. Each high level lasts one cycle.
- R4: done is a one-cycle pulse. zero_err is valid with it and is 0 after any nonzero operation.
- R5: start is ignored while an operation is running. The result belongs to the operand latched at the accepted start, and only one done follows.
- R6: The number of cycles from start to done is the same for every nonzero operand.
- R7: inv_out and zero_err hold their values in every cycle in which done is low.
- R8: After reset, done, zero_err, mul_issue and inv_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an inversion of a_in (accepted only when idle) |
| a_in | input | M | Operand, polynomial basis |
| inv_out | output | M | Inverse of the accepted operand |
| done | output | 1 | One-cycle pulse: inv_out and zero_err are valid |
| zero_err | output | 1 | Operand was zero |
| mul_issue | output | 1 | High in each cycle a field multiplication is performed |

## Verification
The bench sweeps all 8191 nonzero elements of GF(2^13) and checks each result by multiplying it back. A wrong squaring count or a wrong bit order would give a power other than 2^M − 2, and most elements would then fail. For every operand it counts the multiplication strobes against the chain formula. An extra multiplication per exponent bit, or a skipped increment step, would show up here even when the result happened to be right. It checks the latency against the first operand, since a loop that ended early for some inputs would change it. It also checks zero with and without a nonzero operation around it, which would catch a sticky or missing error flag. Finally it sends a second start in the middle of an operation, which a design that re-latched its operand would answer with the wrong inverse or with two done pulses.

// File: rtl/gf_inv_pkg.sv
package gf_inv_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DBL_SQR,
        S_DBL_MUL,
        S_INC_SQR,
        S_INC_MUL,
        S_FINAL
    } inv_state_e;

    // Position of the highest set bit of v (v >= 1); 0 for v <= 1.
    function automatic int msb_pos(input int v);
        int p;
        p = 0;
        for (int i = 0; i < 31; i++) begin
            if ((v >> i) != 0) p = i;
        end
        return p;
    endfunction

endpackage

// File: rtl/gf_reduce.sv
module gf_reduce #(
    parameter int              M    = 13,
    parameter logic [M-1:0]    POLY = 'h1B
) (
    input  logic [2*M-2:0] wide_in,
    output logic [M-1:0]   red_out
);
    logic [2*M-2:0] v;

    // Fold each high coefficient x^i into x^(i-M) * POLY, top down.
    always_comb begin
        v = wide_in;
        for (int i = 2*M-2; i >= M; i--) begin
            if (v[i]) begin
                v[i-M +: M] = v[i-M +: M] ^ POLY;
            end
        end
        red_out = v[M-1:0];
    end
endmodule

// File: rtl/gf_sqr.sv
module gf_sqr #(
    parameter int              M    = 13,
    parameter logic [M-1:0]    POLY = 'h1B
) (
    input  logic [M-1:0] sq_in,
    output logic [M-1:0] sq_out
);
    logic [2*M-2:0] spread;

    // Squaring in characteristic two only interleaves zeros.
    generate
        for (genvar g = 0; g < M; g++) begin : g_spread
            assign spread[2*g] = sq_in[g];
            if (g < M-1) begin : g_gap
                assign spread[2*g+1] = 1'b0;
            end
        end
    endgenerate

    gf_reduce #(.M(M), .POLY(POLY)) u_red (
        .wide_in (spread),
        .red_out (sq_out)
    );
endmodule

// File: rtl/gf_mul.sv
module gf_mul #(
    parameter int              M    = 13,
    parameter logic [M-1:0]    POLY = 'h1B
) (
    input  logic [M-1:0] op_x,
    input  logic [M-1:0] op_y,
    output logic [M-1:0] prod
);
    localparam int WW = 2*M-1;

    logic [WW-1:0] partial [M];
    logic [WW-1:0] raw;

    // Carry-less partial products, one per coefficient of op_y.
    generate
        for (genvar g = 0; g < M; g++) begin : g_pp
            assign partial[g] = op_y[g] ? ({{(M-1){1'b0}}, op_x} << g) : '0;
        end
    endgenerate

    always_comb begin
        raw = '0;
        for (int i = 0; i < M; i++) begin
            raw = raw ^ partial[i];
        end
    end

    gf_reduce #(.M(M), .POLY(POLY)) u_red (
        .wide_in (raw),
        .red_out (prod)
    );
endmodule

// File: rtl/gf_fermat_inv.sv
module gf_fermat_inv
    import gf_inv_pkg::*;
#(
    parameter int              M    = 13,
    parameter logic [M-1:0]    POLY = 'h1B
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] a_in,
    output logic [M-1:0] inv_out,
    output logic         done,
    output logic         zero_err,
    output logic         mul_issue
);
    localparam int            KW    = $clog2(M) + 1;
    localparam int            TOP   = msb_pos(M - 1);
    localparam logic [KW-1:0] E_VEC = KW'(M - 1);
    localparam logic [KW-1:0] TOP_L = KW'(TOP);

    inv_state_e    state_q, state_d;
    logic [M-1:0]  a_q, w_q, t_q, res_q;
    logic [KW-1:0] k_q, cnt_q, bits_q;
    logic          bitv_q, done_q, err_q;

    logic [M-1:0]  sq_w, prod, mul_y;
    logic [KW-1:0] k_nx, bsrc;
    logic          adv_go, a_nz;

    assign a_nz = (a_in != '0);

    gf_sqr #(.M(M), .POLY(POLY)) u_sqr (
        .sq_in  (w_q),
        .sq_out (sq_w)
    );

    assign mul_y = (state_q == S_INC_MUL) ? a_q : t_q;

    gf_mul #(.M(M), .POLY(POLY)) u_mul (
        .op_x (w_q),
        .op_y (mul_y),
        .prod (prod)
    );

    // Chain bookkeeping: new k and remaining bit count at each advance point.
    always_comb begin
        k_nx = k_q;
        bsrc = bits_q;
        unique case (state_q)
            S_IDLE:    begin k_nx = KW'(1);   bsrc = TOP_L;  end
            S_DBL_MUL: begin k_nx = k_q << 1; bsrc = bits_q; end
            S_INC_MUL: begin k_nx = k_q + 1'b1; bsrc = bits_q; end
            default:   begin k_nx = k_q;      bsrc = bits_q; end
        endcase
    end

    assign adv_go = (state_q == S_IDLE && start && a_nz)
                 || (state_q == S_DBL_MUL && !bitv_q)
                 || (state_q == S_INC_MUL);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start && a_nz) state_d = (bsrc == '0) ? S_FINAL : S_DBL_SQR;
            end
            S_DBL_SQR: begin
                if (cnt_q == KW'(1)) state_d = S_DBL_MUL;
            end
            S_DBL_MUL: begin
                if (bitv_q)             state_d = S_INC_SQR;
                else if (bsrc == '0)    state_d = S_FINAL;
                else                    state_d = S_DBL_SQR;
            end
            S_INC_SQR: state_d = S_INC_MUL;
            S_INC_MUL: state_d = (bsrc == '0) ? S_FINAL : S_DBL_SQR;
            S_FINAL:   state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            w_q    <= '0;
            t_q    <= '0;
            k_q    <= '0;
            cnt_q  <= '0;
            bits_q <= '0;
            bitv_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        a_q <= a_in;
                        w_q <= a_in;
                        t_q <= a_in;
                        k_q <= KW'(1);
                    end
                end
                S_DBL_SQR: begin
                    w_q   <= sq_w;
                    cnt_q <= cnt_q - 1'b1;
                end
                S_DBL_MUL: begin
                    w_q <= prod;
                    t_q <= prod;
                    k_q <= k_nx;
                end
                S_INC_SQR: w_q <= sq_w;
                S_INC_MUL: begin
                    w_q <= prod;
                    t_q <= prod;
                    k_q <= k_nx;
                end
                default: ;
            endcase
            if (adv_go && bsrc != '0) begin
                cnt_q  <= k_nx;
                bits_q <= bsrc - 1'b1;
                bitv_q <= E_VEC[bsrc - 1'b1];
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q == S_IDLE && start && !a_nz) begin
                done_q <= 1'b1;
                err_q  <= 1'b1;
                res_q  <= '0;
            end
            if (state_q == S_FINAL) begin
                done_q <= 1'b1;
                err_q  <= 1'b0;
                res_q  <= sq_w;
            end
        end
    end

    assign inv_out   = res_q;
    assign done      = done_q;
    assign zero_err  = err_q;
    assign mul_issue = (state_q == S_DBL_MUL) || (state_q == S_INC_MUL);

    assert_zero_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zero_err) |-> (inv_out == '0));

    assert_mul_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mul_issue |=> !mul_issue);

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_operand_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(a_q));

    assert_sqr_count_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DBL_SQR) |-> (cnt_q != '0));

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(inv_out) && $stable(zero_err)));

endmodule

// File: tb/gf_fermat_inv_tb.sv
module gf_fermat_inv_tb_top;
    localparam int           M    = 13;
    localparam logic [M-1:0] POLY = 13'h001B;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [M-1:0] a_in = '0;
    logic [M-1:0] inv_out;
    logic         done, zero_err, mul_issue;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int exp_mults;
    int lat0 = -1;

    always #2 clk = ~clk;

    gf_fermat_inv #(.M(M), .POLY(POLY)) dut_i (
        .clk (clk), .rst_n (rst_n), .start (start), .a_in (a_in),
        .inv_out (inv_out), .done (done), .zero_err (zero_err),
        .mul_issue (mul_issue)
    );

    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] y);
        logic [M-1:0] acc;
        acc = '0;
        for (int i = M-1; i >= 0; i--) begin
            acc = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? POLY : '0);
            if (y[i]) acc = acc ^ x;
        end
        return acc;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000) begin
            check(1'b0, "watchdog", cyc, 195000);
            finish_run();
        end
    end

    task automatic run_op(input logic [M-1:0] a, output logic [M-1:0] r,
                          output logic e, output int mults, output int lat);
        @(negedge clk);
        a_in  = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mults = 0;
        lat   = 1;
        while (!done && lat < 200) begin
            if (mul_issue) mults++;
            @(negedge clk);
            lat++;
        end
        if (lat >= 200) check(1'b0, "watchdog op", lat, 200);
        r = inv_out;
        e = zero_err;
    endtask

    initial begin
        logic [M-1:0] r, r_hold;
        logic         e;
        int           mults, lat, hw, dn;

        hw = 0;
        for (int i = 0; i < 32; i++) hw += ((M-1) >> i) & 1;
        exp_mults = $clog2(M) - 1 + hw - 1;
        for (int i = 0; i < 31; i++) if (((M-1) >> i) != 0) exp_mults = i + hw - 1;

        // R8: reset state
        repeat (3) @(negedge clk);
        check(done == 0,      "R8 done",      done, 0);
        check(zero_err == 0,  "R8 zero_err",  zero_err, 0);
        check(mul_issue == 0, "R8 mul_issue", mul_issue, 0);
        check(inv_out == 0,   "R8 inv_out",   inv_out, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: zero operand
        run_op('0, r, e, mults, lat);
        check(e == 1,     "R2 zero_err", e, 1);
        check(r == 0,     "R2 inv_out",  r, 0);
        check(mults == 0, "R2 mul count", mults, 0);
        @(negedge clk);
        check(done == 0, "R4 done pulse after zero", done, 0);

        // R1 R3 R4 R6: exhaustive sweep of nonzero elements
        for (int a = 1; a < (1 << M); a++) begin
            run_op(M'(a), r, e, mults, lat);
            check(ref_mul(M'(a), r) == 1, "R1 a*inv", ref_mul(M'(a), r), 1);
            check(mults == exp_mults, "R3 mul count", mults, exp_mults);
            check(e == 0, "R4 zero_err cleared", e, 0);
            if (lat0 < 0) lat0 = lat;
            check(lat == lat0, "R6 latency", lat, lat0);
        end

        // R4 R7: done single cycle, outputs hold afterwards
        run_op(13'h0A5C, r, e, mults, lat);
        r_hold = r;
        dn = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (done) dn++;
            check(inv_out == r_hold, "R7 inv_out hold", inv_out, r_hold);
            check(zero_err == 0, "R7 zero_err hold", zero_err, 0);
        end
        check(dn == 0, "R4 done pulse width", dn, 0);

        // R2 then R4: error set by zero, cleared by a nonzero op
        run_op('0, r, e, mults, lat);
        check(e == 1, "R2 zero_err again", e, 1);
        run_op(13'h0001, r, e, mults, lat);
        check(e == 0, "R4 zero_err cleared", e, 0);
        check(r == 13'h0001, "R1 inverse of one", r, 1);

        // R5: second start while running is ignored
        @(negedge clk);
        a_in = 13'h0005;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        a_in = 13'h0009;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        a_in = '0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        r = inv_out;
        check(ref_mul(13'h0005, r) == 1, "R5 result of first operand", ref_mul(13'h0005, r), 1);
        dn = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done) dn++;
        end
        check(dn == 0, "R5 extra done", dn, 0);
        check(inv_out == r, "R5 result kept", inv_out, r);

        finish_run();
    end
endmodule